// File: doc/BRIEF.md
# Temperature-Indexed Lookup Table Controller

This block turns a stream of signed fixed-point temperature samples into a row index for two 40-entry tables of 8-bit values. On every accepted sample it works out the new row and copies the matching entries into two output setting registers. One register is the V channel, fed from table 1. The other is the G channel, fed from table 2. Rows are 4 °C wide, starting at −40 °C. A move to a lower row needs the temperature to drop 1 °C past the edge of the current row, so a reading that sits on a bin edge does not make the settings chatter.

The sensor's samples arrive on a valid/ready stream. The controller drops `temp_ready` while it is powering up, while automatic conversion is switched off, and while the host bus is busy. A sample is taken only in a cycle where both `temp_valid` and `temp_ready` are high. The source may hold `temp_valid` high for as long as it likes; nothing is taken while `temp_ready` is low. The source sets the update rate, nominally one sample every 10 ms.

A simple register port gives the host access to the state. It writes in one cycle and reads combinationally. The register map is:

| Offset | Contents |
|---|---|
| 60h | table select |
| 61h | configuration |
| 64h | row pointer |
| 70h | V setting |
| 71h | G setting |
| 80h–A7h | table window |

In the configuration byte, bit 3 is a power-up flag. Bit 2 is an update-done flag. Bit 1 enables conversion. Bit 0 enables automatic pointer movement. Clearing bit 1 hands both settings to the host (manual mode). Clearing bit 0 freezes the pointer so the host can aim it at any row and watch which values are loaded (test mode).

Top module: `tlut_ctrl`

## Requirements
- R1: After reset the configuration reads 0Fh, the pointer reads 80h, the table select reads 00h, and both settings and all table entries are 00h.
- R2: Configuration bit 3 resets to 1 and clears to 0 at the first clock edge where `pwr_good` is high. It then stays 0, and host writes never change it. While bit 3 is 1, `temp_ready` is low and samples do not change the pointer or the settings.
- R3: `temp_ready` is high exactly when bit 3 is 0, bit 1 is 1 and `bus_busy` is low. A sample taken at a clock edge updates the pointer, the settings and bit 2 at that same edge. Samples offered while `temp_ready` is low are ignored.
- R4: The sample is 12-bit two's complement in 1/16 °C. The rising bin is floor((T + 40) / 4). When that bin is above the current row, the pointer moves to it, so a row is entered exactly at its lower edge.
- R5: When the rising bin is not above the current row, the pointer moves down only if floor((T + 40 + 15/16) / 4) is below the current row. It then moves to that value, so a drop happens only once T is at or below the current lower edge minus 1 °C.
- R6: Bins below 0 clamp to row 0 (pointer 80h). Bins above 39 clamp to row 39 (pointer A7h). The pointer never leaves 80h–A7h.
- R7: On every load, the V setting takes table 1 at the pointer and the G setting takes table 2 at the pointer.
- R8: Each taken sample sets configuration bit 2. A host write to 61h loads bits 2..0 from write-data bits 2..0. If a write and a sample fall on the same edge, the set wins.
- R9: With bit 1 = 0, host writes to 70h and 71h load the V and G settings directly. With bit 1 = 1, those writes are ignored.
- R10: With bit 0 = 0, taken samples leave the pointer unchanged but still reload both settings from it. A host write to 64h with a value in 80h–A7h moves the pointer, and when bit 1 = 1 it also reloads the settings at that edge. Writes to 64h outside 80h–A7h, or made while bit 0 = 1, are ignored.
- R11: Bit 0 of 60h selects the table for reads and writes at 80h–A7h: 0 selects table 1, 1 selects table 2. Offsets not listed in the map read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_data | input | 12 | Temperature sample, two's complement, 1/16 °C per LSB |
| temp_valid | input | 1 | Sample valid |
| temp_ready | output | 1 | Controller will take the sample this cycle |
| bus_busy | input | 1 | Host bus transfer in progress; holds off conversion |
| pwr_good | input | 1 | Supply has reached its working level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| set_v | output | 8 | V-channel setting |
| set_g | output | 8 | G-channel setting |

## Verification
Every result of this block is due at the same rising edge that takes the sample or the host write that causes it: the pointer, both settings, the done flag and the table contents. `temp_ready` and `reg_rdata` follow the current state with no extra latency. The bench drives inputs on the falling edge. A behavioural model steps on each rising edge, and all four outputs are compared against it a quarter period later. Directed checks read registers and outputs half a period after the edge that took the stimulus, so the one-edge latency is checked in every case.

// File: rtl/tlut_pkg.sv
package tlut_pkg;

  localparam int AW = 8;

  localparam logic [AW-1:0] ADR_SEL  = 8'h60;
  localparam logic [AW-1:0] ADR_CFG  = 8'h61;
  localparam logic [AW-1:0] ADR_PTR  = 8'h64;
  localparam logic [AW-1:0] ADR_SETV = 8'h70;
  localparam logic [AW-1:0] ADR_SETG = 8'h71;
  localparam logic [AW-1:0] ADR_TAB  = 8'h80;

  // bit 3 .. bit 0
  typedef struct packed {
    logic pol;   // power not yet good
    logic tau;   // update done flag
    logic ten;   // conversion enable
    logic aen;   // automatic pointer enable
  } cfg_t;

  localparam cfg_t CFG_RST = '{pol: 1'b1, tau: 1'b1, ten: 1'b1, aen: 1'b1};

endpackage

// File: rtl/tlut_cfg.sv
module tlut_cfg
  import tlut_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       wr_en,
  input  logic [2:0] wr_bits,
  input  logic       upd_done,
  output cfg_t       cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RST;
    end else begin
      if (pwr_good) cfg.pol <= 1'b0;
      if (wr_en) begin
        cfg.tau <= wr_bits[2];
        cfg.ten <= wr_bits[1];
        cfg.aen <= wr_bits[0];
      end
      if (upd_done) cfg.tau <= 1'b1;   // hardware set beats host clear
    end
  end

  a_r2_pol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.pol |=> !cfg.pol);

  a_r8_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> cfg.tau);

endmodule

// File: rtl/tlut_bin.sv
module tlut_bin #(
  parameter int TW       = 12,
  parameter int FRAC     = 4,
  parameter int BIN_LOG2 = 2,
  parameter int LOW_DEG  = -40,
  parameter int HYST_DEG = 1,
  parameter int ENTRIES  = 40,
  parameter int IW       = 6
) (
  input  logic [TW-1:0] temp,
  input  logic [IW-1:0] cur_idx,
  output logic [IW-1:0] nxt_idx
);

  localparam int SW     = TW + 3;
  localparam int OFS    = (-LOW_DEG) * (2 ** FRAC);
  localparam int HYS_M1 = HYST_DEG * (2 ** FRAC) - 1;
  localparam int SH     = BIN_LOG2 + FRAC;

  logic signed [SW-1:0] t_x;
  logic signed [SW-1:0] up_s;
  logic signed [SW-1:0] dn_s;
  logic [IW-1:0]        up_i;
  logic [IW-1:0]        dn_i;

  function automatic logic [IW-1:0] clamp_row(input logic signed [SW-1:0] v);
    if (v < 0)                       return '0;
    else if (v > SW'(ENTRIES - 1))   return IW'(ENTRIES - 1);
    else                             return v[IW-1:0];
  endfunction

  assign t_x  = {{(SW-TW){temp[TW-1]}}, temp};
  assign up_s = (t_x + SW'(OFS)) >>> SH;
  assign dn_s = (t_x + SW'(OFS + HYS_M1)) >>> SH;
  assign up_i = clamp_row(up_s);
  assign dn_i = clamp_row(dn_s);

  always_comb begin
    if (up_i > cur_idx)      nxt_idx = up_i;
    else if (dn_i < cur_idx) nxt_idx = dn_i;
    else                     nxt_idx = cur_idx;
  end

endmodule

// File: rtl/tlut_tables.sv
module tlut_tables #(
  parameter int ENTRIES = 40,
  parameter int DW      = 8,
  parameter int IW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic [IW-1:0] ld_idx,
  output logic [DW-1:0] ld_v,
  output logic [DW-1:0] ld_g
);

  localparam int NB = 2;

  logic [NB-1:0][DW-1:0] rd_w;
  logic [NB-1:0][DW-1:0] ld_w;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      end else if (wr_en && (wr_bank == 1'(b)) && (int'(wr_idx) < ENTRIES)) begin
        mem[wr_idx] <= wr_data;
      end
    end

    assign rd_w[b] = (int'(rd_idx) < ENTRIES) ? mem[rd_idx] : '0;
    assign ld_w[b] = (int'(ld_idx) < ENTRIES) ? mem[ld_idx] : '0;
  end

  assign rd_data = rd_w[rd_bank];
  assign ld_v    = ld_w[0];
  assign ld_g    = ld_w[1];

endmodule

// File: rtl/tlut_ctrl.sv
module tlut_ctrl
  import tlut_pkg::*;
#(
  parameter int ENTRIES  = 40,
  parameter int DW       = 8,
  parameter int TW       = 12,
  parameter int FRAC     = 4,
  parameter int BIN_LOG2 = 2,
  parameter int LOW_DEG  = -40,
  parameter int HYST_DEG = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_data,
  input  logic          temp_valid,
  output logic          temp_ready,
  input  logic          bus_busy,
  input  logic          pwr_good,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] set_v,
  output logic [DW-1:0] set_g
);

  localparam int IW = $clog2(ENTRIES);
  localparam logic [AW-1:0] ADR_TLAST = AW'(int'(ADR_TAB) + ENTRIES - 1);
  localparam logic [DW-1:0] D_TAB     = DW'(ADR_TAB);
  localparam logic [DW-1:0] D_TLAST   = DW'(ADR_TLAST);

  cfg_t          cfg;
  logic          sel_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_n;
  logic [IW-1:0] nxt_idx;
  logic [IW-1:0] tab_idx;
  logic [IW-1:0] ptr_wr_idx;
  logic [DW-1:0] tab_rd;
  logic [DW-1:0] ld_v;
  logic [DW-1:0] ld_g;
  logic          acc;
  logic          load;
  logic          hit_tab;
  logic          ptr_ok;
  logic          wr_sel, wr_cfg, wr_ptr, wr_sv, wr_sg, wr_tab;

  // ---------------- decode ----------------
  assign hit_tab    = (reg_addr >= ADR_TAB) && (reg_addr <= ADR_TLAST);
  assign tab_idx    = IW'(reg_addr - ADR_TAB);
  assign ptr_ok     = (reg_wdata >= D_TAB) && (reg_wdata <= D_TLAST);
  assign ptr_wr_idx = IW'(reg_wdata - D_TAB);

  assign wr_sel = reg_we && (reg_addr == ADR_SEL);
  assign wr_cfg = reg_we && (reg_addr == ADR_CFG);
  assign wr_ptr = reg_we && (reg_addr == ADR_PTR);
  assign wr_sv  = reg_we && (reg_addr == ADR_SETV);
  assign wr_sg  = reg_we && (reg_addr == ADR_SETG);
  assign wr_tab = reg_we && hit_tab;

  // ---------------- sample handshake ----------------
  assign temp_ready = ~cfg.pol & cfg.ten & ~bus_busy;
  assign acc        = temp_valid & temp_ready;

  // ---------------- sub-blocks ----------------
  tlut_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .wr_en    (wr_cfg),
    .wr_bits  (reg_wdata[2:0]),
    .upd_done (acc),
    .cfg      (cfg)
  );

  tlut_bin #(
    .TW       (TW),
    .FRAC     (FRAC),
    .BIN_LOG2 (BIN_LOG2),
    .LOW_DEG  (LOW_DEG),
    .HYST_DEG (HYST_DEG),
    .ENTRIES  (ENTRIES),
    .IW       (IW)
  ) u_bin (
    .temp    (temp_data),
    .cur_idx (ptr_q),
    .nxt_idx (nxt_idx)
  );

  tlut_tables #(
    .ENTRIES (ENTRIES),
    .DW      (DW),
    .IW      (IW)
  ) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_tab),
    .wr_bank (sel_q),
    .wr_idx  (tab_idx),
    .wr_data (reg_wdata),
    .rd_bank (sel_q),
    .rd_idx  (tab_idx),
    .rd_data (tab_rd),
    .ld_idx  (ptr_n),
    .ld_v    (ld_v),
    .ld_g    (ld_g)
  );

  // ---------------- pointer ----------------
  always_comb begin
    ptr_n = ptr_q;
    if (cfg.aen) begin
      if (acc) ptr_n = nxt_idx;
    end else if (wr_ptr && ptr_ok) begin
      ptr_n = ptr_wr_idx;
    end
  end

  assign load = acc | (cfg.ten & ~cfg.aen & wr_ptr & ptr_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      sel_q <= 1'b0;
    end else begin
      ptr_q <= ptr_n;
      if (wr_sel) sel_q <= reg_wdata[0];
    end
  end

  // ---------------- settings ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_v <= '0;
      set_g <= '0;
    end else if (load) begin
      set_v <= ld_v;
      set_g <= ld_g;
    end else if (!cfg.ten) begin
      if (wr_sv) set_v <= reg_wdata;
      if (wr_sg) set_g <= reg_wdata;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    if (hit_tab) begin
      reg_rdata = tab_rd;
    end else begin
      case (reg_addr)
        ADR_SEL:  reg_rdata = DW'(sel_q);
        ADR_CFG:  reg_rdata = DW'(cfg);
        ADR_PTR:  reg_rdata = D_TAB + DW'(ptr_q);
        ADR_SETV: reg_rdata = set_v;
        ADR_SETG: reg_rdata = set_g;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < ENTRIES);

  a_r2_hold_in_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.pol && !reg_we |=> $stable(set_v) && $stable(set_g));

  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy && !reg_we |=> $stable(set_v) && $stable(set_g) && $stable(ptr_q));

  a_r9_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.ten && !reg_we |=> $stable(set_v) && $stable(set_g));

  a_r10_frozen_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.aen && !reg_we |=> $stable(ptr_q));

endmodule

// File: tb/sim_tlut_ctrl.sv
module sim_tlut_ctrl;

  localparam int CLK = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] temp_data = '0;
  logic        temp_valid = 1'b0;
  logic        temp_ready;
  logic        bus_busy = 1'b0;
  logic        pwr_good = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [7:0]  set_v;
  logic [7:0]  set_g;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK/2) clk = ~clk;

  tlut_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .temp_data(temp_data), .temp_valid(temp_valid),
    .temp_ready(temp_ready), .bus_busy(bus_busy), .pwr_good(pwr_good),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .set_v(set_v), .set_g(set_g)
  );

  // ---------------- reference model ----------------
  int tv [40];
  int tg [40];
  int m_idx, m_sv, m_sg;
  bit m_pol, m_tau, m_ten, m_aen, m_sel;

  function automatic int fdiv64(int a);
    if (a >= 0) return a / 64;
    return -((-a + 63) / 64);
  endfunction

  function automatic int clampi(int v);
    if (v < 0) return 0;
    if (v > 39) return 39;
    return v;
  endfunction

  function automatic int next_row(int t, int cur);
    int r, f;
    r = clampi(fdiv64(t + 640));
    f = clampi(fdiv64(t + 655));
    if (r > cur) return r;
    if (f < cur) return f;
    return cur;
  endfunction

  function automatic int mread(logic [7:0] a);
    if (a >= 8'h80 && a <= 8'hA7) return m_sel ? tg[a - 8'h80] : tv[a - 8'h80];
    case (a)
      8'h60: return int'(m_sel);
      8'h61: return int'({m_pol, m_tau, m_ten, m_aen});
      8'h64: return 128 + m_idx;
      8'h70: return m_sv;
      8'h71: return m_sg;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_ready();
    return !m_pol && m_ten && !bus_busy;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 40; i++) begin tv[i] = 0; tg[i] = 0; end
      m_idx = 0; m_sv = 0; m_sg = 0;
      m_pol = 1; m_tau = 1; m_ten = 1; m_aen = 1; m_sel = 0;
    end else begin
      bit acc, wok, ld;
      int t, nidx, widx;
      acc  = temp_valid && m_ready();
      t    = int'($signed(temp_data));
      widx = int'(reg_wdata) - 128;
      wok  = reg_we && reg_addr == 8'h64 && widx >= 0 && widx < 40;
      nidx = m_idx;
      if (m_aen) begin
        if (acc) nidx = next_row(t, m_idx);
      end else if (wok) begin
        nidx = widx;
      end
      ld = acc || (m_ten && !m_aen && wok);
      if (ld) begin
        m_sv = tv[nidx]; m_sg = tg[nidx];
      end else if (!m_ten && reg_we) begin
        if (reg_addr == 8'h70) m_sv = int'(reg_wdata);
        if (reg_addr == 8'h71) m_sg = int'(reg_wdata);
      end
      m_idx = nidx;
      if (reg_we && reg_addr >= 8'h80 && reg_addr <= 8'hA7) begin
        if (m_sel) tg[reg_addr - 8'h80] = int'(reg_wdata);
        else       tv[reg_addr - 8'h80] = int'(reg_wdata);
      end
      if (reg_we && reg_addr == 8'h60) m_sel = reg_wdata[0];
      if (pwr_good) m_pol = 0;
      if (reg_we && reg_addr == 8'h61) begin
        m_tau = reg_wdata[2]; m_ten = reg_wdata[1]; m_aen = reg_wdata[0];
      end
      if (acc) m_tau = 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK/4);
    if (rst_n && !done) begin
      chk(cur_req, "model set_v", int'(set_v), m_sv);
      chk(cur_req, "model set_g", int'(set_g), m_sg);
      chk(cur_req, "model temp_ready", int'(temp_ready), int'(m_ready()));
      chk(cur_req, "model reg_rdata", int'(reg_rdata), mread(reg_addr));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input int exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, $sformatf("read %02h", a), int'(reg_rdata), exp);
  endtask

  task automatic send(input int t);
    @(negedge clk);
    temp_data = 12'(t); temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  function automatic int ev(int i); return (i * 5 + 3) & 255; endfunction
  function automatic int eg(int i); return (255 - i * 6) & 255; endfunction

  task automatic send_chk(input string req, input int t, input int row);
    send(t);
    chk(req, "set_v after sample", int'(set_v), ev(row));
    chk(req, "set_g after sample", int'(set_g), eg(row));
    rd(req, 8'h64, 128 + row);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    rd("R1", 8'h61, 8'h0F);
    rd("R1", 8'h64, 8'h80);
    rd("R1", 8'h60, 8'h00);
    rd("R1", 8'h92, 8'h00);
    chk("R1", "set_v reset", int'(set_v), 0);
    chk("R1", "set_g reset", int'(set_g), 0);

    cur_req = "R11";
    for (int i = 0; i < 40; i++) wr(8'h80 + 8'(i), 8'(ev(i)));
    wr(8'h60, 8'h01);
    for (int i = 0; i < 40; i++) wr(8'h80 + 8'(i), 8'(eg(i)));
    wr(8'h60, 8'h00);

    cur_req = "R2";
    chk("R2", "ready before power good", int'(temp_ready), 0);
    send(400);
    rd("R2", 8'h64, 8'h80);
    chk("R2", "set_v held in power-up", int'(set_v), 0);
    wr(8'h61, 8'h07);
    rd("R2", 8'h61, 8'h0F);
    @(negedge clk); pwr_good = 1'b1;
    @(negedge clk); pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    rd("R2", 8'h61, 8'h07);
    chk("R3", "ready after power good", int'(temp_ready), 1);

    cur_req = "R6";
    send_chk("R6", -800, 0);
    send_chk("R6", -641, 0);
    cur_req = "R4";
    send_chk("R4", -640, 0);
    send_chk("R4", -576, 1);
    send_chk("R4", 400, 16);
    cur_req = "R5";
    send_chk("R5", 369, 16);
    send_chk("R5", 368, 15);
    send_chk("R5", 376, 15);
    cur_req = "R4";
    send_chk("R4", 384, 16);
    cur_req = "R5";
    send_chk("R5", -160, 7);
    cur_req = "R6";
    send_chk("R6", 2047, 39);
    send_chk("R6", 1856, 39);
    send_chk("R5", 1840, 38);
    send_chk("R6", -2048, 0);

    cur_req = "R3";
    @(negedge clk); bus_busy = 1'b1;
    #1 chk("R3", "ready while busy", int'(temp_ready), 0);
    send(2047);
    rd("R3", 8'h64, 8'h80);
    @(negedge clk); bus_busy = 1'b0;

    cur_req = "R8";
    wr(8'h61, 8'h03);
    rd("R8", 8'h61, 8'h03);
    send_chk("R8", 400, 16);
    rd("R8", 8'h61, 8'h07);

    cur_req = "R9";
    wr(8'h61, 8'h05);
    rd("R9", 8'h61, 8'h05);
    send(-640);
    rd("R9", 8'h64, 8'h90);
    wr(8'h70, 8'hAA);
    wr(8'h71, 8'h55);
    chk("R9", "manual set_v", int'(set_v), 8'hAA);
    chk("R9", "manual set_g", int'(set_g), 8'h55);
    wr(8'h61, 8'h07);
    wr(8'h70, 8'h11);
    chk("R9", "host write ignored when converting", int'(set_v), 8'hAA);
    cur_req = "R7";
    send_chk("R7", -576, 1);

    cur_req = "R10";
    wr(8'h61, 8'h06);
    wr(8'h64, 8'h85);
    chk("R10", "test mode load v", int'(set_v), ev(5));
    chk("R10", "test mode load g", int'(set_g), eg(5));
    send(2047);
    rd("R10", 8'h64, 8'h85);
    wr(8'h85, 8'h99);
    send(0);
    chk("R10", "reload at held pointer", int'(set_v), 8'h99);
    chk("R7", "g follows table 2", int'(set_g), eg(5));
    wr(8'h64, 8'hA8);
    rd("R10", 8'h64, 8'h85);
    wr(8'h64, 8'h7F);
    rd("R10", 8'h64, 8'h85);
    wr(8'h64, 8'hA7);
    chk("R10", "last row v", int'(set_v), ev(39));
    chk("R10", "last row g", int'(set_g), eg(39));
    wr(8'h61, 8'h04);
    wr(8'h64, 8'h80);
    rd("R10", 8'h64, 8'h80);
    chk("R9", "manual keeps settings on pointer write", int'(set_v), ev(39));

    cur_req = "R11";
    wr(8'h60, 8'h01);
    rd("R11", 8'h80, eg(0));
    rd("R11", 8'hA7, eg(39));
    wr(8'h60, 8'h00);
    rd("R11", 8'h81, ev(1));
    rd("R11", 8'h85, 8'h99);
    rd("R11", 8'h65, 8'h00);
    rd("R11", 8'h72, 8'h00);

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule